// File: doc/BRIEF.md
# SPI Flash Command Opcode Parser

This block sits behind the byte deserialiser of an SPI device that presents itself as a serial flash. It watches the first byte that arrives in a transaction and looks it up in a table of command descriptors that software loads at run time. Each descriptor is a valid bit and an 8-bit opcode. The slots of the table are assigned to fixed command classes: status reads, ID read, discoverable-parameter read, 4-byte address enter and exit, write enable and disable, a group of data-read commands, and upload commands.

Once a descriptor hits, the parser moves from Idle into a state for that command class. It also drives a one-hot datapath select that tells the downstream handlers which of them owns the rest of the transaction. The matched descriptor and its slot number are captured in the same cycle. In passthrough mode, the three read-class commands are answered locally only when their per-class intercept enable is set, and a registered intercept flag records that decision. Without the enable, the command is left to the downstream flash: the parser parks in Wait and selects no handler. The reset input is tied to chip-select deassertion, so exactly one opcode is decoded per transaction.

With the default parameters the slot layout is as follows: status reads in slots 0..2, ID read in slot 3, parameter read in slot 4, enter-4B in slot 5, exit-4B in slot 6, write enable in slot 7, write disable in slot 8, data reads in slots 9..12 and uploads in slots 13..15.

Top module: `spi_opc_parser`

## Requirements
- R1: While `rst_n` is low at a clock edge, the parser resets to the following state: `state_o` = 0 (Idle), `dp_sel_o` = 10'b1 (NONE), all intercept flags 0, `desc_valid_o` = 0. After reset, `state_o` and `dp_sel_o` are never unknown.
- R2: A slot hits only when its bit in `tbl_valid_i` is 1 and its opcode field `tbl_opcode_i[8*i +: 8]` equals `byte_i`. When several slots hit, the lowest slot index wins.
- R3: `mode_i` encodes 0 = flash, 1 = passthrough, 2 and 3 = inactive. In an inactive mode, received bytes are ignored and the state stays Idle.
- R4: The state leaves Idle only on a clock edge where all of these hold: the state is Idle, the mode is active, `byte_valid_i` is 1, and some slot hits. A byte that hits nothing leaves the parser in Idle, ready for the next byte. Once out of Idle, the state, the select and the flags hold until reset, and later bytes are ignored.
- R5: On the leaving edge, `desc_valid_o`, `desc_opcode_o` and `desc_slot_o` capture the winning descriptor and its slot index.
- R6: In flash mode, the read-class commands always go to their handler state. A status slot goes to state 1 with select bit 1. The ID slot goes to state 2 with bit 2. The parameter slot goes to state 3 with bit 3. No intercept flag is set.
- R7: In passthrough mode, a read-class command with its enable set goes to its handler state and sets its own flag (`icpt_status_o`, `icpt_jedec_o` or `icpt_sfdp_o`). With the enable clear, it goes to Wait (state 8) with select NONE and no flag. At most one flag is ever set, and none outside passthrough.
- R8: A data-read slot goes to state 4 with select bit 4. An upload slot goes to state 5 with select bit 5.
- R9: Enter-4B and exit-4B both go to state 6, with select bits 6 and 7 respectively. Write enable and write disable both go to state 7, with select bits 8 and 9 respectively.
- R10: Exactly one bit of `dp_sel_o` is set at all times. Bit 0 (NONE) is used in Idle and Wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (chip-select inactive) |
| mode_i | input | 2 | Device mode: 0 flash, 1 passthrough, 2/3 inactive |
| byte_valid_i | input | 1 | `byte_i` holds a complete received byte |
| byte_i | input | 8 | Received byte |
| tbl_valid_i | input | 16 | Per-slot descriptor valid bits |
| tbl_opcode_i | input | 128 | Per-slot opcodes, slot i in bits 8*i+7..8*i |
| icpt_en_status_i | input | 1 | Answer status reads locally in passthrough |
| icpt_en_jedec_i | input | 1 | Answer ID reads locally in passthrough |
| icpt_en_sfdp_i | input | 1 | Answer parameter reads locally in passthrough |
| state_o | output | 4 | Parser state code |
| dp_sel_o | output | 10 | One-hot datapath select |
| icpt_status_o | output | 1 | Status read intercepted |
| icpt_jedec_o | output | 1 | ID read intercepted |
| icpt_sfdp_o | output | 1 | Parameter read intercepted |
| desc_valid_o | output | 1 | Captured descriptor is valid |
| desc_opcode_o | output | 8 | Captured opcode |
| desc_slot_o | output | 4 | Slot index of the captured descriptor |

## Verification
The assertions check several properties on every cycle. The select stays one-hot and is NONE in Idle. No unknown appears on state or select. A non-idle state freezes state, select and flags. Inactive modes and missing byte strobes keep the parser in Idle. The intercept flags stay at most one-hot and clear outside passthrough. Other properties need known table contents, so only the directed scenarios can show them: the choice of class for a given opcode, lowest-index priority between duplicate opcodes, rejection of invalid or unequal entries, the Wait-versus-handler split under each intercept enable, and the captured slot and opcode.

// File: rtl/spi_opc_pkg.sv
// Shared types for the opcode parser: state codes, command classes and
// datapath select bit positions. Assumes an 8-bit opcode wide byte lane.
package spi_opc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_STATUS = 4'd1,
        ST_JEDEC  = 4'd2,
        ST_SFDP   = 4'd3,
        ST_READ   = 4'd4,
        ST_UPLOAD = 4'd5,
        ST_ADDR4B = 4'd6,
        ST_WREN   = 4'd7,
        ST_WAIT   = 4'd8
    } opc_state_e;

    typedef enum logic [3:0] {
        CLS_STATUS,
        CLS_JEDEC,
        CLS_SFDP,
        CLS_EN4B,
        CLS_EX4B,
        CLS_WREN,
        CLS_WRDI,
        CLS_READ,
        CLS_UPLOAD
    } opc_class_e;

    localparam int DP_W      = 10;
    localparam int DP_NONE   = 0;
    localparam int DP_STATUS = 1;
    localparam int DP_JEDEC  = 2;
    localparam int DP_SFDP   = 3;
    localparam int DP_READ   = 4;
    localparam int DP_UPLOAD = 5;
    localparam int DP_EN4B   = 6;
    localparam int DP_EX4B   = 7;
    localparam int DP_WREN   = 8;
    localparam int DP_WRDI   = 9;

    localparam logic [1:0] MODE_FLASH = 2'd0;
    localparam logic [1:0] MODE_PASS  = 2'd1;

endpackage

// File: rtl/spi_opc_match.sv
// Compares the received byte against every descriptor slot in parallel and
// returns the lowest hitting slot. Assumes opcodes are packed slot 0 first.
module spi_opc_match #(
    parameter int NUM_SLOTS = 16,
    parameter int OP_W      = 8,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic [OP_W-1:0]           byte_i,
    input  logic [NUM_SLOTS-1:0]      tbl_valid_i,
    input  logic [NUM_SLOTS*OP_W-1:0] tbl_opcode_i,
    output logic                      hit_o,
    output logic [SLOT_W-1:0]         slot_o
);

    logic [NUM_SLOTS-1:0] slot_hit;

    // One comparator per slot: valid bit and equal opcode are both needed.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        assign slot_hit[g] = tbl_valid_i[g] &&
                             (tbl_opcode_i[g*OP_W +: OP_W] == byte_i);
    end

    // Priority pick: scanning downward leaves the lowest hitting index.
    always_comb begin
        hit_o  = 1'b0;
        slot_o = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (slot_hit[i]) begin
                hit_o  = 1'b1;
                slot_o = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/spi_opc_classify.sv
// Maps a slot index onto its fixed command class. Assumes the layout:
// status slots, ID, parameter read, enter-4B, exit-4B, write enable,
// write disable, data-read slots, then upload slots to the end.
module spi_opc_classify #(
    parameter int NUM_SLOTS  = 16,
    parameter int NUM_STATUS = 3,
    parameter int NUM_READ   = 4,
    parameter int SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic [SLOT_W-1:0]       slot_i,
    output spi_opc_pkg::opc_class_e class_o
);
    import spi_opc_pkg::*;

    localparam int S_JEDEC = NUM_STATUS;
    localparam int S_SFDP  = NUM_STATUS + 1;
    localparam int S_EN4B  = NUM_STATUS + 2;
    localparam int S_EX4B  = NUM_STATUS + 3;
    localparam int S_WREN  = NUM_STATUS + 4;
    localparam int S_WRDI  = NUM_STATUS + 5;
    localparam int S_RD_LO = NUM_STATUS + 6;
    localparam int S_RD_HI = S_RD_LO + NUM_READ;

    logic [31:0] s_ext;

    // Range decode of the slot index into its class.
    always_comb begin
        s_ext = 32'(slot_i);
        if (s_ext < 32'(NUM_STATUS))      class_o = CLS_STATUS;
        else if (s_ext == 32'(S_JEDEC))   class_o = CLS_JEDEC;
        else if (s_ext == 32'(S_SFDP))    class_o = CLS_SFDP;
        else if (s_ext == 32'(S_EN4B))    class_o = CLS_EN4B;
        else if (s_ext == 32'(S_EX4B))    class_o = CLS_EX4B;
        else if (s_ext == 32'(S_WREN))    class_o = CLS_WREN;
        else if (s_ext == 32'(S_WRDI))    class_o = CLS_WRDI;
        else if (s_ext < 32'(S_RD_HI))    class_o = CLS_READ;
        else                              class_o = CLS_UPLOAD;
    end

endmodule

// File: rtl/spi_opc_fsm.sv
// Parser state machine: leaves Idle once per transaction on a hitting byte,
// picks the handler state, datapath select and intercept flags, then holds
// them until reset. Assumes reset marks the end of a transaction.
module spi_opc_fsm (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take_i,
    input  logic                          pass_i,
    input  spi_opc_pkg::opc_class_e       class_i,
    input  logic                          en_status_i,
    input  logic                          en_jedec_i,
    input  logic                          en_sfdp_i,
    output spi_opc_pkg::opc_state_e       state_o,
    output logic [spi_opc_pkg::DP_W-1:0]  dp_sel_o,
    output logic [2:0]                    icpt_o
);
    import spi_opc_pkg::*;

    opc_state_e    st_nx;
    int            dp_idx;
    logic [2:0]    icpt_nx;
    logic [DP_W-1:0] dp_nx;

    // Next state, select index and intercept flags for the decoded class.
    always_comb begin
        st_nx   = ST_WAIT;
        dp_idx  = DP_NONE;
        icpt_nx = 3'b000;
        unique case (class_i)
            CLS_STATUS: begin
                if (!pass_i || en_status_i) begin
                    st_nx   = ST_STATUS;
                    dp_idx  = DP_STATUS;
                    icpt_nx = {2'b00, pass_i};
                end
            end
            CLS_JEDEC: begin
                if (!pass_i || en_jedec_i) begin
                    st_nx   = ST_JEDEC;
                    dp_idx  = DP_JEDEC;
                    icpt_nx = {1'b0, pass_i, 1'b0};
                end
            end
            CLS_SFDP: begin
                if (!pass_i || en_sfdp_i) begin
                    st_nx   = ST_SFDP;
                    dp_idx  = DP_SFDP;
                    icpt_nx = {pass_i, 2'b00};
                end
            end
            CLS_READ:   begin st_nx = ST_READ;   dp_idx = DP_READ;   end
            CLS_UPLOAD: begin st_nx = ST_UPLOAD; dp_idx = DP_UPLOAD; end
            CLS_EN4B:   begin st_nx = ST_ADDR4B; dp_idx = DP_EN4B;   end
            CLS_EX4B:   begin st_nx = ST_ADDR4B; dp_idx = DP_EX4B;   end
            CLS_WREN:   begin st_nx = ST_WREN;   dp_idx = DP_WREN;   end
            CLS_WRDI:   begin st_nx = ST_WREN;   dp_idx = DP_WRDI;   end
            default:    begin st_nx = ST_WAIT;   dp_idx = DP_NONE;   end
        endcase
        dp_nx         = '0;
        dp_nx[dp_idx] = 1'b1;
    end

    // State, select and flags: reset to Idle/NONE, loaded once on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o  <= ST_IDLE;
            dp_sel_o <= DP_W'(1) << DP_NONE;
            icpt_o   <= 3'b000;
        end else if (take_i) begin
            state_o  <= st_nx;
            dp_sel_o <= dp_nx;
            icpt_o   <= icpt_nx;
        end
    end

endmodule

// File: rtl/spi_opc_parser.sv
// Top of the opcode parser. Gates on device mode, looks the first byte up in
// the descriptor table, classifies the winning slot, runs the state machine
// and captures the winning descriptor. Assumes rst_n follows chip-select.
module spi_opc_parser #(
    parameter int NUM_SLOTS  = 16,
    parameter int NUM_STATUS = 3,
    parameter int NUM_READ   = 4,
    parameter int OP_W       = 8,
    parameter int SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    mode_i,
    input  logic                          byte_valid_i,
    input  logic [OP_W-1:0]               byte_i,
    input  logic [NUM_SLOTS-1:0]          tbl_valid_i,
    input  logic [NUM_SLOTS*OP_W-1:0]     tbl_opcode_i,
    input  logic                          icpt_en_status_i,
    input  logic                          icpt_en_jedec_i,
    input  logic                          icpt_en_sfdp_i,
    output logic [3:0]                    state_o,
    output logic [spi_opc_pkg::DP_W-1:0]  dp_sel_o,
    output logic                          icpt_status_o,
    output logic                          icpt_jedec_o,
    output logic                          icpt_sfdp_o,
    output logic                          desc_valid_o,
    output logic [OP_W-1:0]               desc_opcode_o,
    output logic [SLOT_W-1:0]             desc_slot_o
);
    import spi_opc_pkg::*;

    logic        active, pass, hit, take;
    logic [SLOT_W-1:0] slot;
    opc_class_e  cls;
    opc_state_e  st;
    logic [2:0]  icpt;

    // Mode gating: only flash and passthrough decode bytes.
    assign active = (mode_i == MODE_FLASH) || (mode_i == MODE_PASS);
    assign pass   = (mode_i == MODE_PASS);
    assign take   = (st == ST_IDLE) && active && byte_valid_i && hit;

    spi_opc_match #(
        .NUM_SLOTS (NUM_SLOTS),
        .OP_W      (OP_W),
        .SLOT_W    (SLOT_W)
    ) u_match (
        .byte_i       (byte_i),
        .tbl_valid_i  (tbl_valid_i),
        .tbl_opcode_i (tbl_opcode_i),
        .hit_o        (hit),
        .slot_o       (slot)
    );

    spi_opc_classify #(
        .NUM_SLOTS  (NUM_SLOTS),
        .NUM_STATUS (NUM_STATUS),
        .NUM_READ   (NUM_READ),
        .SLOT_W     (SLOT_W)
    ) u_cls (
        .slot_i  (slot),
        .class_o (cls)
    );

    spi_opc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .pass_i      (pass),
        .class_i     (cls),
        .en_status_i (icpt_en_status_i),
        .en_jedec_i  (icpt_en_jedec_i),
        .en_sfdp_i   (icpt_en_sfdp_i),
        .state_o     (st),
        .dp_sel_o    (dp_sel_o),
        .icpt_o      (icpt)
    );

    // Descriptor capture on the leaving edge; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_valid_o  <= 1'b0;
            desc_opcode_o <= '0;
            desc_slot_o   <= '0;
        end else if (take) begin
            desc_valid_o  <= tbl_valid_i[slot];
            desc_opcode_o <= tbl_opcode_i[slot*OP_W +: OP_W];
            desc_slot_o   <= slot;
        end
    end

    assign state_o       = st;
    assign icpt_status_o = icpt[0];
    assign icpt_jedec_o  = icpt[1];
    assign icpt_sfdp_o   = icpt[2];

endmodule

// File: rtl/spi_opc_parser_chk.sv
// Cycle-by-cycle checks on the parser's ports, attached by bind.
module spi_opc_parser_chk (
    input logic                         clk,
    input logic                         rst_n,
    input logic [1:0]                   mode_i,
    input logic                         byte_valid_i,
    input logic [3:0]                   state_o,
    input logic [spi_opc_pkg::DP_W-1:0] dp_sel_o,
    input logic                         icpt_status_o,
    input logic                         icpt_jedec_o,
    input logic                         icpt_sfdp_o
);
    logic [2:0] flags;
    assign flags = {icpt_sfdp_o, icpt_jedec_o, icpt_status_o};

    assert_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({state_o, dp_sel_o}));

    assert_dp_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dp_sel_o) == 1);

    assert_idle_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd0) |-> dp_sel_o[0]);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 4'd0) |=> ($stable(state_o) && $stable(dp_sel_o) && $stable(flags)));

    assert_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd0 && !byte_valid_i) |=> (state_o == 4'd0));

    assert_inactive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd0 && mode_i[1]) |=> (state_o == 4'd0));

    assert_flags_onehot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    assert_flags_pass_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd0 && mode_i != 2'd1) |=> (flags == 3'b000));

endmodule

bind spi_opc_parser spi_opc_parser_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .byte_valid_i  (byte_valid_i),
    .state_o       (state_o),
    .dp_sel_o      (dp_sel_o),
    .icpt_status_o (icpt_status_o),
    .icpt_jedec_o  (icpt_jedec_o),
    .icpt_sfdp_o   (icpt_sfdp_o)
);

// File: tb/spi_opc_parser_tb.sv
`timescale 1ns/1ps
module spi_opc_parser_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [15:0] tbl_valid_i = 16'hFFFF;
    logic [127:0] tbl_opcode_i;
    logic        en_st = 1'b0, en_jd = 1'b0, en_sf = 1'b0;
    logic [3:0]  state_o;
    logic [9:0]  dp_sel_o;
    logic        icpt_status_o, icpt_jedec_o, icpt_sfdp_o;
    logic        desc_valid_o;
    logic [7:0]  desc_opcode_o;
    logic [3:0]  desc_slot_o;
    logic [7:0]  opt [16];

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // Pack the per-slot opcode list into the flat table port.
    always_comb
        for (int i = 0; i < 16; i++) tbl_opcode_i[i*8 +: 8] = opt[i];

    spi_opc_parser u_dut (
        .clk (clk), .rst_n (rst_n), .mode_i (mode_i),
        .byte_valid_i (byte_valid_i), .byte_i (byte_i),
        .tbl_valid_i (tbl_valid_i), .tbl_opcode_i (tbl_opcode_i),
        .icpt_en_status_i (en_st), .icpt_en_jedec_i (en_jd), .icpt_en_sfdp_i (en_sf),
        .state_o (state_o), .dp_sel_o (dp_sel_o),
        .icpt_status_o (icpt_status_o), .icpt_jedec_o (icpt_jedec_o),
        .icpt_sfdp_o (icpt_sfdp_o), .desc_valid_o (desc_valid_o),
        .desc_opcode_o (desc_opcode_o), .desc_slot_o (desc_slot_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    // Expected state, select bit and flags {sfdp,jedec,status}.
    task automatic expect_out(input string tag, input int st, input int dpbit, input int fl);
        check({tag, " state"}, int'(state_o), st);
        check({tag, " dp_sel"}, int'(dp_sel_o), 1 << dpbit);
        check({tag, " flags"}, int'({icpt_sfdp_o, icpt_jedec_o, icpt_status_o}), fl);
        check({tag, " R10 onehot"}, $countones(dp_sel_o), 1);
    endtask

    task automatic load_table();
        opt[0] = 8'h05; opt[1] = 8'h35; opt[2] = 8'h15; opt[3] = 8'h9F;
        opt[4] = 8'h5A; opt[5] = 8'hB7; opt[6] = 8'hE9; opt[7] = 8'h06;
        opt[8] = 8'h04; opt[9] = 8'h03; opt[10] = 8'h0B; opt[11] = 8'h3B;
        opt[12] = 8'h6B; opt[13] = 8'h02; opt[14] = 8'h20; opt[15] = 8'hD8;
        tbl_valid_i = 16'hFFFF;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one byte for one cycle; output is sampled one negedge later.
    task automatic send(input logic [7:0] b);
        byte_i = b;
        byte_valid_i = 1'b1;
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    task automatic txn(input logic [1:0] m, input logic [7:0] b);
        mode_i = m;
        do_reset();
        send(b);
    endtask

    task automatic t_reset();
        do_reset();
        expect_out("R1 reset", 0, 0, 0);
        check("R1 desc_valid", int'(desc_valid_o), 0);
    endtask

    task automatic t_flash_reads();
        en_st = 0; en_jd = 0; en_sf = 0;
        txn(2'd0, 8'h35); expect_out("R6 flash status", 1, 1, 0);
        txn(2'd0, 8'h9F); expect_out("R6 flash jedec", 2, 2, 0);
        txn(2'd0, 8'h5A); expect_out("R6 flash sfdp", 3, 3, 0);
        en_st = 1; en_jd = 1; en_sf = 1;
        txn(2'd0, 8'h05); expect_out("R6 flash status en", 1, 1, 0);
    endtask

    task automatic t_passthrough();
        en_st = 1; en_jd = 1; en_sf = 1;
        txn(2'd1, 8'h05); expect_out("R7 pass status icpt", 1, 1, 1);
        txn(2'd1, 8'h9F); expect_out("R7 pass jedec icpt", 2, 2, 2);
        txn(2'd1, 8'h5A); expect_out("R7 pass sfdp icpt", 3, 3, 4);
        en_st = 0; en_jd = 0; en_sf = 0;
        txn(2'd1, 8'h15); expect_out("R7 pass status fwd", 8, 0, 0);
        txn(2'd1, 8'h9F); expect_out("R7 pass jedec fwd", 8, 0, 0);
        txn(2'd1, 8'h5A); expect_out("R7 pass sfdp fwd", 8, 0, 0);
        en_jd = 1;
        txn(2'd1, 8'h5A); expect_out("R7 pass sfdp other en", 8, 0, 0);
        en_jd = 0;
    endtask

    task automatic t_other_classes();
        txn(2'd0, 8'h0B); expect_out("R8 read", 4, 4, 0);
        txn(2'd1, 8'h6B); expect_out("R8 read pass", 4, 4, 0);
        txn(2'd0, 8'hD8); expect_out("R8 upload", 5, 5, 0);
        txn(2'd0, 8'hB7); expect_out("R9 en4b", 6, 6, 0);
        txn(2'd0, 8'hE9); expect_out("R9 ex4b", 6, 7, 0);
        txn(2'd0, 8'h06); expect_out("R9 wren", 7, 8, 0);
        txn(2'd0, 8'h04); expect_out("R9 wrdi", 7, 9, 0);
    endtask

    task automatic t_match_rules();
        tbl_valid_i[3] = 1'b0;
        txn(2'd0, 8'h9F); expect_out("R2 invalid equal", 0, 0, 0);
        tbl_valid_i[3] = 1'b1;
        txn(2'd0, 8'h77); expect_out("R2 no opcode", 0, 0, 0);
        send(8'h03); expect_out("R4 retry after miss", 4, 4, 0);
        opt[13] = 8'h03;
        txn(2'd0, 8'h03);
        check("R2 lowest slot wins", int'(desc_slot_o), 9);
        expect_out("R2 dup class", 4, 4, 0);
        tbl_valid_i[9] = 1'b0;
        txn(2'd0, 8'h03);
        check("R2 next slot when low invalid", int'(desc_slot_o), 13);
        expect_out("R2 dup upload", 5, 5, 0);
        load_table();
    endtask

    task automatic t_mode_gate();
        txn(2'd2, 8'h06); expect_out("R3 mode2 ignored", 0, 0, 0);
        txn(2'd3, 8'h9F); expect_out("R3 mode3 ignored", 0, 0, 0);
        mode_i = 2'd0;
        send(8'h06); expect_out("R3 flash after inactive", 7, 8, 0);
    endtask

    task automatic t_hold();
        txn(2'd0, 8'h06);
        send(8'h9F); expect_out("R4 later byte ignored", 7, 8, 0);
        check("R4 desc kept", int'(desc_opcode_o), 8'h06);
        mode_i = 2'd0;
        do_reset();
        byte_i = 8'h9F; byte_valid_i = 1'b0;
        @(negedge clk);
        expect_out("R4 no strobe", 0, 0, 0);
    endtask

    task automatic t_desc();
        txn(2'd0, 8'h15);
        check("R5 desc valid", int'(desc_valid_o), 1);
        check("R5 desc opcode", int'(desc_opcode_o), 8'h15);
        check("R5 desc slot", int'(desc_slot_o), 2);
        txn(2'd0, 8'hD8);
        check("R5 desc slot upload", int'(desc_slot_o), 15);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        load_table();
        t_reset();
        t_flash_reads();
        t_passthrough();
        t_other_classes();
        t_match_rules();
        t_mode_gate();
        t_hold();
        t_desc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule